// File: doc/BRIEF.md
# Thread Block Admission and Warp Slicer

This block sits in front of a multiprocessor's warp pool. A launch request arrives with three block dimensions and a block identifier. The block checks the request against three occupancy limits: threads per block, threads resident on the multiprocessor, and blocks resident. It then slices the admitted block into warps of 32 threads. Thread numbering runs with the x coordinate changing fastest. For each warp the block produces one descriptor: block identifier, warp number, the linear index of the warp's first thread, and a lane-enable mask.

Both sides use valid/ready handshakes. A request that fits the per-block rules but not the current free capacity is held, with ready low, until block-complete pulses free enough room. A request that can never run is accepted and dropped, and it raises an error pulse. Blocks may complete in any order. Each completion pulse carries the thread count to give back.

Top module: `blk_warp_dispatch`

## Requirements
- R1: A launch whose thread count x*y*z exceeds 512 is accepted, produces no descriptor, and raises `lq_err` for exactly the cycle after the handshake.
- R2: A launch with x, y or z equal to zero is treated like R1: accepted, `lq_err` raised one cycle later, and no descriptor.
- R3: Resident threads never exceed 1024. A valid launch that would cross this limit sees `lq_ready` low until capacity is freed.
- R4: At most 8 blocks are resident. A ninth valid launch sees `lq_ready` low until a block completes.
- R5: Warp k of a block carries the block's identifier, `wd_warp_idx` = k and `wd_base` = 32*k. Warps are numbered from 0 with no gaps, and a block of n threads yields ceil(n/32) descriptors.
- R6: Bit i of `wd_mask` enables thread `wd_base`+i. Every warp except the last has all 32 bits set. The last warp of a block whose thread count n is not a multiple of 32 has only its low n mod 32 bits set.
- R7: Descriptors leave one per accepted `wd_valid`/`wd_ready` handshake. While `wd_ready` is low, the descriptor is held unchanged. `lq_ready` stays low from the handshake of an admitted launch until its last descriptor is accepted, so the warps of two blocks never interleave.
- R8: A `done_pulse` cycle returns `done_threads` threads and one block slot. A launch held by R3 or R4 sees `lq_ready` high in the next cycle if the freed room is enough.
- R9: After reset, `wd_valid` and `lq_err` are low, no threads or blocks are resident, and `lq_ready` is high for any launch that fits in an empty multiprocessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lq_valid | input | 1 | Launch request valid |
| lq_ready | output | 1 | Launch request accepted this cycle when high with valid |
| lq_dim_x | input | DIMW | Block x dimension |
| lq_dim_y | input | DIMW | Block y dimension |
| lq_dim_z | input | DIMW | Block z dimension |
| lq_id | input | IDW | Block identifier |
| lq_err | output | 1 | One-cycle pulse after a rejected launch |
| wd_valid | output | 1 | Warp descriptor valid |
| wd_ready | input | 1 | Warp descriptor taken |
| wd_blk_id | output | IDW | Identifier of the block owning the warp |
| wd_warp_idx | output | IW | Warp number within the block |
| wd_base | output | BTW | Linear index of the warp's first thread |
| wd_mask | output | WARP | Lane-enable mask |
| done_pulse | input | 1 | One resident block has completed |
| done_threads | input | BTW | Thread count of the completed block |

## Verification
`lq_ready` is combinational on the current residency and request, so the bench reads it in the same half cycle as the request it judges. Residency changes from an admission or a completion show up in `lq_ready` one edge later. The error pulse and the first descriptor of a block are registered, so both are due in the cycle after the launch handshake. Each later descriptor is due one cycle after the previous one was taken. All inputs change on the falling edge, and every check samples at a falling edge, at the count of edges these rules give.

// File: rtl/blk_warp_dispatch.sv
module blk_warp_dispatch #(
  parameter int WARP        = 32,
  parameter int MAX_BLK_THR = 512,
  parameter int MAX_SM_THR  = 1024,
  parameter int MAX_BLKS    = 8,
  parameter int DIMW        = 10,
  parameter int IDW         = 8,
  localparam int LW  = $clog2(WARP),
  localparam int IW  = $clog2(MAX_BLK_THR / WARP),
  localparam int BTW = $clog2(MAX_BLK_THR + 1),
  localparam int TW  = $clog2(MAX_SM_THR + 1),
  localparam int BW  = $clog2(MAX_BLKS + 1),
  localparam int PW  = 3 * DIMW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lq_valid,
  output logic            lq_ready,
  input  logic [DIMW-1:0] lq_dim_x,
  input  logic [DIMW-1:0] lq_dim_y,
  input  logic [DIMW-1:0] lq_dim_z,
  input  logic [IDW-1:0]  lq_id,
  output logic            lq_err,
  output logic            wd_valid,
  input  logic            wd_ready,
  output logic [IDW-1:0]  wd_blk_id,
  output logic [IW-1:0]   wd_warp_idx,
  output logic [BTW-1:0]  wd_base,
  output logic [WARP-1:0] wd_mask,
  input  logic            done_pulse,
  input  logic [BTW-1:0]  done_threads
);

  logic [TW-1:0]  res_thr;
  logic [BW-1:0]  res_blk;
  logic           busy;
  logic [BTW-1:0] cur_cnt;
  logic [PW-1:0]  prod;
  logic [BTW-1:0] cnt;
  logic           bad, fit, acc, acc_ok, last;
  logic [BTW-1:0] rem;

  assign prod = PW'(lq_dim_x) * PW'(lq_dim_y) * PW'(lq_dim_z);
  assign bad  = (lq_dim_x == '0) || (lq_dim_y == '0) || (lq_dim_z == '0) ||
                (prod > PW'(MAX_BLK_THR));
  assign cnt  = prod[BTW-1:0];
  assign fit  = ((TW+1)'(res_thr) + (TW+1)'(cnt) <= (TW+1)'(MAX_SM_THR)) &&
                (res_blk < BW'(MAX_BLKS));

  assign lq_ready = !busy && (bad || fit);
  assign acc      = lq_valid && lq_ready;
  assign acc_ok   = acc && !bad;

  assign wd_valid = busy;
  assign wd_base  = BTW'(wd_warp_idx) << LW;
  assign rem      = cur_cnt - wd_base;
  assign last     = rem <= BTW'(WARP);
  assign wd_mask  = (rem >= BTW'(WARP)) ? '1 : ((WARP'(1) << rem[LW-1:0]) - WARP'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_thr     <= '0;
      res_blk     <= '0;
      busy        <= 1'b0;
      cur_cnt     <= '0;
      wd_blk_id   <= '0;
      wd_warp_idx <= '0;
      lq_err      <= 1'b0;
    end else begin
      lq_err  <= acc && bad;
      res_thr <= res_thr + (acc_ok ? TW'(cnt) : TW'(0)) - (done_pulse ? TW'(done_threads) : TW'(0));
      res_blk <= res_blk + (acc_ok ? BW'(1) : BW'(0)) - (done_pulse ? BW'(1) : BW'(0));
      if (acc_ok) begin
        busy        <= 1'b1;
        cur_cnt     <= cnt;
        wd_blk_id   <= lq_id;
        wd_warp_idx <= '0;
      end else if (busy && wd_ready) begin
        if (last) busy <= 1'b0;
        else      wd_warp_idx <= wd_warp_idx + IW'(1);
      end
    end
  end

  p_err_no_warp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lq_err |-> !wd_valid);
  p_thr_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_thr <= TW'(MAX_SM_THR));
  p_blk_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_blk <= BW'(MAX_BLKS));
  p_mask_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid |-> (wd_mask[0] && ((wd_mask & (wd_mask + WARP'(1))) == '0)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_base) && $stable(wd_mask) && $stable(wd_blk_id)));
  p_serial_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid |-> !lq_ready);

endmodule

// File: tb/test_blk_warp_dispatch.sv
module test_blk_warp_dispatch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lq_valid = 1'b0;
  logic lq_ready;
  logic [9:0] lq_dim_x = '0, lq_dim_y = '0, lq_dim_z = '0;
  logic [7:0] lq_id = '0;
  logic lq_err;
  logic wd_valid;
  logic wd_ready = 1'b0;
  logic [7:0] wd_blk_id;
  logic [3:0] wd_warp_idx;
  logic [9:0] wd_base;
  logic [31:0] wd_mask;
  logic done_pulse = 1'b0;
  logic [9:0] done_threads = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  blk_warp_dispatch i_blk_warp_dispatch (
    .clk(clk), .rst_n(rst_n), .lq_valid(lq_valid), .lq_ready(lq_ready),
    .lq_dim_x(lq_dim_x), .lq_dim_y(lq_dim_y), .lq_dim_z(lq_dim_z), .lq_id(lq_id),
    .lq_err(lq_err), .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_blk_id(wd_blk_id),
    .wd_warp_idx(wd_warp_idx), .wd_base(wd_base), .wd_mask(wd_mask),
    .done_pulse(done_pulse), .done_threads(done_threads));

  // {err, warps, last mask, x, y, z}
  localparam logic [67:0] VEC [10] = '{
    {1'b0, 5'd1,  32'hffffffff, 10'd32, 10'd1,  10'd1},
    {1'b0, 5'd1,  32'h3fffffff, 10'd5,  10'd3,  10'd2},
    {1'b0, 5'd4,  32'h0000000f, 10'd10, 10'd10, 10'd1},
    {1'b0, 5'd16, 32'hffffffff, 10'd8,  10'd8,  10'd8},
    {1'b0, 5'd2,  32'h00000001, 10'd33, 10'd1,  10'd1},
    {1'b1, 5'd0,  32'h00000000, 10'd16, 10'd4,  10'd9},
    {1'b1, 5'd0,  32'h00000000, 10'd0,  10'd4,  10'd4},
    {1'b1, 5'd0,  32'h00000000, 10'd7,  10'd1,  10'd0},
    {1'b0, 5'd1,  32'h00000001, 10'd1,  10'd1,  10'd1},
    {1'b0, 5'd5,  32'h003fffff, 10'd3,  10'd1,  10'd50}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input int x, input int y, input int z, input int id);
    int g = 0;
    lq_dim_x = 10'(x); lq_dim_y = 10'(y); lq_dim_z = 10'(z); lq_id = 8'(id);
    lq_valid = 1'b1;
    #1;
    while (!lq_ready && g < 100) begin @(negedge clk); g++; end
    @(negedge clk);
    lq_valid = 1'b0;
  endtask

  task automatic drain(input int id, input int nw, input logic [31:0] lastm);
    int k = 0;
    int g = 0;
    wd_ready = 1'b1;
    while (k < nw && g < 200) begin
      if (wd_valid) begin
        chk(wd_blk_id == 8'(id), "R5 id", wd_blk_id, id);
        chk(wd_warp_idx == 4'(k), "R5 idx", wd_warp_idx, k);
        chk(wd_base == 10'(32 * k), "R5 base", wd_base, 32 * k);
        chk(wd_mask == ((k == nw - 1) ? lastm : 32'hffffffff), "R6 mask", wd_mask,
            (k == nw - 1) ? lastm : 32'hffffffff);
        k++;
      end
      @(negedge clk);
      g++;
    end
    chk(k == nw, "R5 count", k, nw);
    chk(!wd_valid, "R7 end of block", wd_valid, 0);
    wd_ready = 1'b0;
  endtask

  task automatic finish_blk(input int n);
    done_threads = 10'(n);
    done_pulse = 1'b1;
    @(negedge clk);
    done_pulse = 1'b0;
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lq_dim_x = 10'd8; lq_dim_y = 10'd8; lq_dim_z = 10'd8;
    #1;
    chk(!wd_valid, "R9 wd_valid", wd_valid, 0);
    chk(!lq_err, "R9 lq_err", lq_err, 0);
    chk(lq_ready, "R9 lq_ready", lq_ready, 1);
    @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      logic [67:0] e;
      e = VEC[v];
      launch(int'(e[29:20]), int'(e[19:10]), int'(e[9:0]), v + 3);
      chk(lq_err == e[67], e[67] ? "R1/R2 err pulse" : "R1 no err", lq_err, e[67]);
      if (e[67]) begin
        @(negedge clk);
        chk(!wd_valid, "R1 R2 no warp", wd_valid, 0);
        chk(!lq_err, "R1 err one cycle", lq_err, 0);
      end else begin
        drain(v + 3, int'(e[66:62]), e[61:30]);
        finish_blk(int'(e[29:20]) * int'(e[19:10]) * int'(e[9:0]));
      end
    end

    // stall holds descriptor; launch side blocked meanwhile
    launch(10, 10, 1, 77);
    for (int c = 0; c < 3; c++) begin
      chk(wd_valid && wd_base == 10'd0 && wd_mask == 32'hffffffff, "R7 hold", wd_base, 0);
      chk(!lq_ready, "R7 launch blocked", lq_ready, 0);
      @(negedge clk);
    end
    drain(77, 4, 32'h0000000f);
    finish_blk(100);

    // thread occupancy
    launch(8, 8, 8, 1); drain(1, 16, 32'hffffffff);
    launch(8, 8, 8, 2); drain(2, 16, 32'hffffffff);
    lq_dim_x = 10'd1; lq_dim_y = 10'd1; lq_dim_z = 10'd1; lq_valid = 1'b1;
    #1;
    chk(!lq_ready, "R3 held at 1024", lq_ready, 0);
    lq_valid = 1'b0;
    finish_blk(512);
    #1;
    chk(lq_ready, "R8 freed threads", lq_ready, 1);
    launch(1, 1, 1, 5); drain(5, 1, 32'h1);
    finish_blk(512);
    finish_blk(1);

    // block slots
    for (int b = 0; b < 8; b++) begin
      launch(1, 1, 1, 40 + b);
      drain(40 + b, 1, 32'h1);
    end
    lq_dim_x = 10'd1; lq_dim_y = 10'd1; lq_dim_z = 10'd1; lq_valid = 1'b1;
    #1;
    chk(!lq_ready, "R4 ninth block held", lq_ready, 0);
    lq_valid = 1'b0;
    finish_blk(1);
    #1;
    chk(lq_ready, "R8 freed slot", lq_ready, 1);
    launch(1, 1, 1, 60);
    drain(60, 1, 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule